// File: doc/BRIEF.md
# Hardware/Software Selectable Clock Gate Controller

This block decides, cycle by cycle, whether one clock should run, and drives a gate-enable signal meant for a glitch-free gating cell placed next to it. A small control register chooses who owns the decision. In automatic mode the consumer logic asks for the clock on a request input and the gate follows that request. In software mode a register bit turns the clock on or off directly. The owner can be switched at any time by rewriting the register.

Turning the clock on takes effect at the next clock edge. Turning it off can be delayed by a selectable hold-off, either one cycle, a short window or a long window. The request must stay low for the whole window, and a request that comes back inside the window restarts it. A read-only status bit in the same register reports the gate's real state one cycle late, so software writes a change and then polls the status bit until it matches. A build option gives a variant with no disable: whenever software owns the gate, the clock stays on.

Top module: `hwsw_clk_gate`

## Requirements
- R1: After reset the register reads 0x13: bit 1 (owner select) = 1 (software), bit 0 (software enable) = 1, bit 4 (status) = 1, bits 2 and 3 (hold-off enable and hold-off length) = 0, upper bits 0. `gate_en` is 1.
- R2: With bit 1 = 1, the requested state is bit 0. Bit 0 = 1 requests the clock on and 0 requests it off.
- R3: With bit 1 = 0, the requested state is `hw_req`, and bit 0 has no effect on `gate_en`.
- R4: When the requested state is on at a clock edge, `gate_en` is 1 after that edge.
- R5: With bit 2 = 0, `gate_en` falls at the first edge where the requested state is off.
- R6: With bit 2 = 1 and bit 3 = 0, `gate_en` falls at the SHORT_DLY-th (default 4) consecutive edge with the request off. A request that comes back on inside the window restarts the count.
- R7: With bit 2 = 1 and bit 3 = 1, `gate_en` falls at the LONG_DLY-th (default 32) consecutive edge with the request off.
- R8: Bit 4 reads the value `gate_en` had one cycle earlier.
- R9: Bit 4 is read-only. A write with bit 4 set does not change it.
- R10: With NO_DISABLE = 1 and bit 1 = 1, `gate_en` stays 1 whatever bit 0 holds. With bit 1 = 0, this variant still follows `hw_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | REG_W | Write data |
| hw_req | input | 1 | Automatic clock request from the consumer logic |
| reg_rdata | output | REG_W | Register read value, including the status bit |
| gate_en | output | 1 | Enable for the gating cell |

## Verification
The hardest case to reach from the ports is a hold-off window that is broken part way through. The request has to be low for fewer edges than the window and then high again for a single edge. Only after that can the full restarted window be measured. The bench counts edges on the falling clock and pulses `hw_req` for exactly one cycle after three low edges. It checks that the gate never dropped, and then that a fresh low period takes the full short window. A behavioural model compared on every cycle also catches any off-by-one in the long window and in the status lag.

// File: rtl/hwsw_clk_gate_pkg.sv
package hwsw_clk_gate_pkg;
   // Control register bit positions (software decodes these)
   localparam int unsigned B_SWEN  = 0;  // software enable
   localparam int unsigned B_OWNER = 1;  // 1: software owns gate, 0: automatic
   localparam int unsigned B_HOEN  = 2;  // hold-off enable
   localparam int unsigned B_HOLNG = 3;  // hold-off length: 1 long, 0 short
   localparam int unsigned B_STAT  = 4;  // read-only gate status
   localparam int unsigned MIN_REG_W = 5;

   typedef struct packed {
      logic ho_long;
      logic ho_en;
      logic owner_sw;
      logic sw_en;
   } gate_cfg_t;

   localparam gate_cfg_t CFG_RESET = '{ho_long: 1'b0, ho_en: 1'b0,
                                       owner_sw: 1'b1, sw_en: 1'b1};
endpackage

// File: rtl/hwsw_clk_gate_regs.sv
module hwsw_clk_gate_regs
   import hwsw_clk_gate_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output gate_cfg_t        cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RESET;
      end else if (we) begin
         cfg.sw_en    <= wdata[B_SWEN];
         cfg.owner_sw <= wdata[B_OWNER];
         cfg.ho_en    <= wdata[B_HOEN];
         cfg.ho_long  <= wdata[B_HOLNG];
      end
   end
endmodule

// File: rtl/hwsw_clk_gate_src.sv
module hwsw_clk_gate_src
   import hwsw_clk_gate_pkg::*;
#(
   parameter bit NO_DISABLE = 1'b0
) (
   input  gate_cfg_t cfg,
   input  logic      hw_req,
   output logic      want_on
);
   logic sw_side;

   if (NO_DISABLE) begin : g_forced_on
      assign sw_side = 1'b1;
   end else begin : g_sw_bit
      assign sw_side = cfg.sw_en;
   end

   assign want_on = cfg.owner_sw ? sw_side : hw_req;
endmodule

// File: rtl/hwsw_clk_gate_holdoff.sv
module hwsw_clk_gate_holdoff #(
   parameter int unsigned SHORT_DLY = 4,
   parameter int unsigned LONG_DLY  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want_on,
   input  logic ho_en,
   input  logic ho_long,
   output logic gate_en
);
   localparam int unsigned CNT_W = $clog2(LONG_DLY + 1);
   localparam logic [CNT_W-1:0] LIM_ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_DLY);
   localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_DLY);

   logic [CNT_W-1:0] low_cnt;
   logic [CNT_W-1:0] limit;
   logic             expire;

   always_comb begin
      if (!ho_en)       limit = LIM_ONE;
      else if (ho_long) limit = LIM_LONG;
      else              limit = LIM_SHORT;
   end

   assign expire = (low_cnt >= (limit - LIM_ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_en <= 1'b1;
         low_cnt <= '0;
      end else if (want_on) begin
         gate_en <= 1'b1;
         low_cnt <= '0;
      end else if (gate_en) begin
         if (expire) begin
            gate_en <= 1'b0;
            low_cnt <= '0;
         end else begin
            low_cnt <= low_cnt + LIM_ONE;
         end
      end
   end
endmodule

// File: rtl/hwsw_clk_gate.sv
module hwsw_clk_gate
   import hwsw_clk_gate_pkg::*;
#(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned SHORT_DLY  = 4,
   parameter int unsigned LONG_DLY   = 32,
   parameter bit          NO_DISABLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             hw_req,
   output logic [REG_W-1:0] reg_rdata,
   output logic             gate_en
);
   if (REG_W < MIN_REG_W) begin : g_bad_width
      $error("REG_W too small for the control fields");
   end
   if (SHORT_DLY < 1 || LONG_DLY < SHORT_DLY) begin : g_bad_delay
      $error("need 1 <= SHORT_DLY <= LONG_DLY");
   end

   gate_cfg_t cfg;
   logic      want_on;
   logic      status_q;

   hwsw_clk_gate_regs #(.REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .cfg(cfg)
   );

   hwsw_clk_gate_src #(.NO_DISABLE(NO_DISABLE)) u_src (
      .cfg(cfg), .hw_req(hw_req), .want_on(want_on)
   );

   hwsw_clk_gate_holdoff #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_hold (
      .clk(clk), .rst_n(rst_n), .want_on(want_on),
      .ho_en(cfg.ho_en), .ho_long(cfg.ho_long), .gate_en(gate_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= 1'b1;
      else        status_q <= gate_en;
   end

   always_comb begin
      reg_rdata          = '0;
      reg_rdata[B_SWEN]  = cfg.sw_en;
      reg_rdata[B_OWNER] = cfg.owner_sw;
      reg_rdata[B_HOEN]  = cfg.ho_en;
      reg_rdata[B_HOLNG] = cfg.ho_long;
      reg_rdata[B_STAT]  = status_q;
   end
endmodule

// File: rtl/hwsw_clk_gate_chk.sv
module hwsw_clk_gate_chk
   import hwsw_clk_gate_pkg::*;
#(
   parameter int unsigned REG_W      = 8,
   parameter bit          NO_DISABLE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_req,
   input logic [REG_W-1:0] reg_rdata,
   input logic             gate_en
);
   logic req_seen;
   assign req_seen = reg_rdata[B_OWNER] ?
                     (NO_DISABLE ? 1'b1 : reg_rdata[B_SWEN]) : hw_req;

   // R4: a request for the clock turns the gate on at the next edge
   a_r4_on_next: assert property (@(posedge clk) disable iff (!rst_n)
      req_seen |=> gate_en);

   // R5: without hold-off the gate drops at the first low-request edge
   a_r5_fast_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[B_HOEN] && !req_seen && gate_en) |=> !gate_en);

   // R2: the gate only falls after an edge that saw no request
   a_r2_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_en) |-> $past(!req_seen));

   // R8: status bit is the gate one cycle late
   a_r8_status_lag: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (reg_rdata[B_STAT] == $past(gate_en)));

   // R10: forced-on variant keeps the clock while software owns it
   a_r10_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
      (NO_DISABLE && reg_rdata[B_OWNER] && $past(reg_rdata[B_OWNER])) |-> gate_en);
endmodule

bind hwsw_clk_gate hwsw_clk_gate_chk #(.REG_W(REG_W), .NO_DISABLE(NO_DISABLE)) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_rdata(reg_rdata), .gate_en(gate_en)
);

// File: tb/hwsw_clk_gate_test.sv
module hwsw_clk_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [RW-1:0] reg_wdata = '0;
   logic          hw_req = 1'b1;
   logic [RW-1:0] rdata, rdata_nd;
   logic          gate, gate_nd;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   string phase = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   hwsw_clk_gate #(.REG_W(RW), .SHORT_DLY(4), .LONG_DLY(32), .NO_DISABLE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .hw_req(hw_req), .reg_rdata(rdata), .gate_en(gate));

   hwsw_clk_gate #(.REG_W(RW), .SHORT_DLY(4), .LONG_DLY(32), .NO_DISABLE(1'b1)) uut_nd (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .hw_req(hw_req), .reg_rdata(rdata_nd), .gate_en(gate_nd));

   // behavioural reference model of the default instance
   bit m_en = 1, m_sel = 1, m_hen = 0, m_hlong = 0, m_gate = 1, m_stat = 1;
   int m_low = 0;

   always @(posedge clk) begin
      bit req;
      int dly;
      if (!rst_n) begin
         m_en = 1; m_sel = 1; m_hen = 0; m_hlong = 0; m_gate = 1; m_stat = 1; m_low = 0;
      end else begin
         req = m_sel ? m_en : hw_req;
         dly = !m_hen ? 1 : (m_hlong ? 32 : 4);
         m_stat = m_gate;
         if (req) begin
            m_gate = 1; m_low = 0;
         end else if (m_gate) begin
            m_low++;
            if (m_low >= dly) begin m_gate = 0; m_low = 0; end
         end
         if (reg_we) begin
            m_en = reg_wdata[0]; m_sel = reg_wdata[1];
            m_hen = reg_wdata[2]; m_hlong = reg_wdata[3];
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(phase, "gate_en vs model", int'(gate), int'(m_gate));
         check(phase, "rdata vs model", int'(rdata),
               int'({m_stat, m_hlong, m_hen, m_sel, m_en}));
      end
   end

   function automatic logic [RW-1:0] cfgw(bit sel, bit en, bit hen, bit hlong, bit st);
      return {3'b000, st, hlong, hen, sel, en};
   endfunction

   task automatic wr(input logic [RW-1:0] d);
      @(negedge clk); reg_we = 1'b1; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic wait_gate(input logic val, output int n);
      n = 0;
      while (gate !== val && n < 100) begin @(negedge clk); n++; end
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "rdata at reset", int'(rdata), 'h13);
      check("R1", "gate at reset", int'(gate), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 + R5: software off, no hold-off
      phase = "R2";
      wr(cfgw(1, 0, 0, 0, 0));
      wait_gate(1'b0, n);
      check("R5", "edges to off without hold-off", n, 1);
      check("R10", "forced-on variant stays on in software mode", int'(gate_nd), 1);
      repeat (2) @(negedge clk);
      check("R2", "gate stays off with bit0=0", int'(gate), 0);

      // R4: turn on
      phase = "R4";
      wr(cfgw(1, 1, 0, 0, 0));
      wait_gate(1'b1, n);
      check("R4", "edges to on", n, 1);

      // R6: short hold-off
      phase = "R6";
      wr(cfgw(1, 0, 1, 0, 0));
      wait_gate(1'b0, n);
      check("R6", "edges to off short window", n, 4);
      wr(cfgw(1, 1, 1, 0, 0));
      wait_gate(1'b1, n);

      // R7: long hold-off
      phase = "R7";
      wr(cfgw(1, 0, 1, 1, 0));
      wait_gate(1'b0, n);
      check("R7", "edges to off long window", n, 32);
      wr(cfgw(1, 1, 0, 0, 0));
      wait_gate(1'b1, n);

      // R3: automatic mode, bit0 ignored
      phase = "R3";
      hw_req = 1'b1;
      wr(cfgw(0, 1, 0, 0, 0));
      hw_req = 1'b0;
      wait_gate(1'b0, n);
      check("R3", "follows hw_req low despite bit0=1", n, 1);
      check("R10", "forced-on variant follows hw_req in auto mode", int'(gate_nd), 0);
      wr(cfgw(0, 1, 0, 0, 0));
      repeat (3) @(negedge clk);
      check("R3", "bit0 rewrite has no effect", int'(gate), 0);
      hw_req = 1'b1;
      wait_gate(1'b1, n);
      check("R3", "follows hw_req high", n, 1);

      // R6 restart: broken window
      phase = "R6";
      wr(cfgw(0, 0, 1, 0, 0));
      hw_req = 1'b0;
      repeat (3) @(negedge clk);
      check("R6", "still on after 3 low edges", int'(gate), 1);
      hw_req = 1'b1;
      @(negedge clk);
      hw_req = 1'b0;
      wait_gate(1'b0, n);
      check("R6", "restarted window full length", n, 4);

      // R9: status read-only
      phase = "R9";
      wr(cfgw(0, 0, 0, 0, 1));
      @(negedge clk);
      check("R9", "status unaffected by write", int'(rdata[4]), 0);

      // R8: status lag
      phase = "R8";
      hw_req = 1'b1;
      @(negedge clk);
      check("R8", "gate on, status still old", int'({gate, rdata[4]}), 2);
      @(negedge clk);
      check("R8", "status follows one cycle later", int'(rdata[4]), 1);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule